// File: doc/BRIEF.md
# Hart Debug-Mode Entry Controller

This block holds the debug control and status register of one hart and runs the state machine that decides when the hart halts into Debug Mode and when it leaves it. The register is reached at CSR address 0x7B0 through a simple read/write port. Reads and writes take effect only while the hart is halted. The core reports events as one-cycle strobes: EBREAK retired, trigger hit, instruction retired, and halt, halt-group, reset-halt and resume requests. The block answers with a halted flag, the recorded entry cause, the privilege to resume at, an interrupt mask for stepping, and freeze enables for the counters and the timer.

The machine has four states. `ST_BOOT` is the first cycle after reset. `ST_BOOT -> ST_HALT` is taken when the reset-halt request is high, and `ST_BOOT -> ST_RUN` otherwise. `ST_RUN` is normal execution and `ST_HALT` is Debug Mode. `ST_STEP` is a single step in progress. `ST_RUN -> ST_HALT` and `ST_STEP -> ST_HALT` are taken on any entry event. `ST_HALT -> ST_STEP` is taken on resume when the step bit is set, and `ST_HALT -> ST_RUN` on resume when it is clear. On every entry the cause code and the current privilege are stored in the register.

Top module: `hart_halt_ctrl`

## Requirements
- R1: After reset all writable fields and the cause field are 0. If `reset_halt_req` is high in the first cycle after reset, the hart enters Debug Mode with cause 5. Otherwise it runs, and `reset_halt_req` has no effect from then on.
- R2: Register access is honoured only while halted and only at address 0x7B0. In all other cases `csr_rdata` is 0 and writes leave every field unchanged.
- R3: The register image is laid out as follows. Bits 31:28 read 4 and ignore writes. Bit 15 is the M-mode EBREAK enable, bit 13 the S-mode enable and bit 12 the U-mode enable. Bit 11 is the step interrupt enable, bit 10 the counter freeze and bit 9 the timer freeze. Bits 8:6 hold the cause and ignore writes. Bit 2 is step and bits 1:0 are the resume privilege. All other bits read 0.
- R4: An EBREAK retired while running enters Debug Mode when the enable bit for `cur_priv` is 1 (privilege 0=U, 1=S, 3=M). When that bit is 0, `bkpt_exc` is high in the same cycle and the EBREAK causes no entry.
- R5: An entry event sampled at a clock edge raises `debug_mode` after that edge. While halted, `entry_cause` is never 0 and uses these codes: 1 EBREAK, 2 trigger, 3 halt request, 4 step, 5 reset halt, 6 halt group.
- R6: When several entry events occur in one cycle, the recorded cause follows this priority, highest first: reset halt, trigger, EBREAK, step, halt request, halt group.
- R7: A resume with step=1 leaves Debug Mode. The first instruction retired after that re-enters Debug Mode with cause 4, and cycles without a retired instruction do not. A resume with step=0 keeps running across retired instructions.
- R8: `irq_mask` is high exactly while a step is in progress and the step interrupt enable bit is 0.
- R9: When the counter freeze bit is 1, `count_freeze` is high while halted. It is also high in the cycle of an EBREAK that enters Debug Mode.
- R10: When the timer freeze bit is 1, `time_freeze` is high while halted. With `HAS_STOPTIME=0` the bit reads 0 and `time_freeze` stays 0.
- R11: On entry, the resume privilege field captures `cur_priv`, and `resume_priv` always shows that field. A write of the reserved value 2 leaves the field unchanged.
- R12: While halted, `resume_req` clears `debug_mode` after the next edge. Outside Debug Mode, `resume_req` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | CSR_AW | CSR address |
| csr_we | input | 1 | CSR write strobe |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data, 0 unless a halted access hits 0x7B0 |
| cur_priv | input | 2 | Privilege the hart is running at |
| ebreak_ret | input | 1 | EBREAK retired |
| trig_hit | input | 1 | Trigger fired |
| halt_req | input | 1 | Debugger halt request |
| reset_halt_req | input | 1 | Halt out of reset |
| group_halt_req | input | 1 | Halt-group request |
| resume_req | input | 1 | Debugger resume request |
| instr_ret | input | 1 | Instruction retired |
| debug_mode | output | 1 | Hart is in Debug Mode |
| entry_cause | output | 3 | Recorded entry cause |
| resume_priv | output | 2 | Privilege to resume at |
| irq_mask | output | 1 | Mask interrupts during the step |
| count_freeze | output | 1 | Stop hart-local counters |
| time_freeze | output | 1 | Stop timers |
| bkpt_exc | output | 1 | EBREAK goes to the breakpoint exception |

## Verification
Directed sequences cover several cases. One raises trigger, EBREAK and halt together, then EBREAK and halt together, which separates a correct priority order from a swapped one. Another runs a step with idle cycles before the retirement, which shows a design that re-enters on any cycle rather than on a retired instruction. EBREAK is applied at each privilege with its enable both set and clear, which checks the per-privilege routing. Writes of the reserved privilege and writes made while running check the ignore rules. A long seeded random run mixes every strobe and full-width write data. A second instance built without the timer freeze receives the same stimulus.

// File: rtl/halt_ctrl_pkg.sv
package halt_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_RUN,
        ST_HALT,
        ST_STEP
    } hc_state_t;

    localparam logic [2:0] CAUSE_EBREAK  = 3'd1;
    localparam logic [2:0] CAUSE_TRIG    = 3'd2;
    localparam logic [2:0] CAUSE_HALT    = 3'd3;
    localparam logic [2:0] CAUSE_STEP    = 3'd4;
    localparam logic [2:0] CAUSE_RSTHALT = 3'd5;
    localparam logic [2:0] CAUSE_GROUP   = 3'd6;

    localparam logic [1:0] PRIV_U    = 2'd0;
    localparam logic [1:0] PRIV_S    = 2'd1;
    localparam logic [1:0] PRIV_RSVD = 2'd2;
    localparam logic [1:0] PRIV_M    = 2'd3;

    localparam logic [3:0] DBG_VERSION = 4'd4;

    typedef struct packed {
        logic       brk_m;
        logic       brk_s;
        logic       brk_u;
        logic       step_irq_en;
        logic       freeze_cnt;
        logic       freeze_tmr;
        logic [2:0] why;
        logic       single_step;
        logic [1:0] ret_priv;
    } hc_fields_t;

endpackage

// File: rtl/halt_cause_arb.sv
module halt_cause_arb
    import halt_ctrl_pkg::*;
#(
    parameter int N_SRC = 6
) (
    input  logic [N_SRC-1:0] req,      // bit 0 has the highest priority
    output logic             valid,
    output logic [2:0]       cause
);

    function automatic logic [2:0] src_code(input int idx);
        case (idx)
            0:       return CAUSE_RSTHALT;
            1:       return CAUSE_TRIG;
            2:       return CAUSE_EBREAK;
            3:       return CAUSE_STEP;
            4:       return CAUSE_HALT;
            default: return CAUSE_GROUP;
        endcase
    endfunction

    always_comb begin
        valid = |req;
        cause = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) cause = src_code(i);
        end
    end

endmodule

// File: rtl/halt_csr_file.sv
module halt_csr_file
    import halt_ctrl_pkg::*;
#(
    parameter int XLEN         = 32,
    parameter bit HAS_STOPTIME = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wdata,
    input  logic            cap_en,
    input  logic [2:0]      cap_cause,
    input  logic [1:0]      cap_priv,
    output hc_fields_t      fld,
    output logic [XLEN-1:0] img
);

    localparam int PAD_W = XLEN - 32;

    hc_fields_t fld_q;
    logic       tmr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q <= '0;
        end else if (cap_en) begin
            fld_q.why      <= cap_cause;
            fld_q.ret_priv <= cap_priv;
        end else if (wr_en) begin
            fld_q.brk_m       <= wdata[15];
            fld_q.brk_s       <= wdata[13];
            fld_q.brk_u       <= wdata[12];
            fld_q.step_irq_en <= wdata[11];
            fld_q.freeze_cnt  <= wdata[10];
            fld_q.single_step <= wdata[2];
            if (wdata[1:0] != PRIV_RSVD) fld_q.ret_priv <= wdata[1:0];
        end
    end

    generate
        if (HAS_STOPTIME) begin : g_tmr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                tmr_q <= 1'b0;
                else if (wr_en && !cap_en) tmr_q <= wdata[9];
            end
        end else begin : g_no_tmr
            assign tmr_q = 1'b0;
        end
    endgenerate

    always_comb begin
        fld            = fld_q;
        fld.freeze_tmr = tmr_q;
    end

    logic [31:0] img32;
    always_comb begin
        img32         = '0;
        img32[31:28]  = DBG_VERSION;
        img32[15]     = fld.brk_m;
        img32[13]     = fld.brk_s;
        img32[12]     = fld.brk_u;
        img32[11]     = fld.step_irq_en;
        img32[10]     = fld.freeze_cnt;
        img32[9]      = fld.freeze_tmr;
        img32[8:6]    = fld.why;
        img32[2]      = fld.single_step;
        img32[1:0]    = fld.ret_priv;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign img = {{PAD_W{1'b0}}, img32};
        end else begin : g_nopad
            assign img = img32;
        end
    endgenerate

    logic unused_wbits;
    assign unused_wbits = ^{wdata[XLEN-1:16], wdata[14], wdata[8:3], fld_q.freeze_tmr};

endmodule

// File: rtl/hart_halt_ctrl.sv
module hart_halt_ctrl
    import halt_ctrl_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter int              CSR_AW       = 12,
    parameter logic [CSR_AW-1:0] CSR_ADDR   = 12'h7B0,
    parameter bit              HAS_STOPTIME = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic              csr_we,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    input  logic [1:0]        cur_priv,
    input  logic              ebreak_ret,
    input  logic              trig_hit,
    input  logic              halt_req,
    input  logic              reset_halt_req,
    input  logic              group_halt_req,
    input  logic              resume_req,
    input  logic              instr_ret,
    output logic              debug_mode,
    output logic [2:0]        entry_cause,
    output logic [1:0]        resume_priv,
    output logic              irq_mask,
    output logic              count_freeze,
    output logic              time_freeze,
    output logic              bkpt_exc
);

    localparam int N_SRC = 6;

    hc_state_t        state_q, state_d;
    hc_fields_t       fld;
    logic [XLEN-1:0]  img;
    logic             addr_hit, wr_en, running, brk_en, brk_go;
    logic [N_SRC-1:0] entry_req;
    logic             arb_valid;
    logic [2:0]       arb_cause;

    assign addr_hit = (csr_addr == CSR_ADDR);
    assign wr_en    = csr_we && addr_hit && (state_q == ST_HALT);
    assign running  = (state_q == ST_RUN) || (state_q == ST_STEP);

    always_comb begin
        unique case (cur_priv)
            PRIV_M:  brk_en = fld.brk_m;
            PRIV_S:  brk_en = fld.brk_s;
            PRIV_U:  brk_en = fld.brk_u;
            default: brk_en = 1'b0;
        endcase
    end

    assign brk_go = running && ebreak_ret && brk_en;

    assign entry_req[0] = (state_q == ST_BOOT) && reset_halt_req;
    assign entry_req[1] = running && trig_hit;
    assign entry_req[2] = brk_go;
    assign entry_req[3] = (state_q == ST_STEP) && instr_ret;
    assign entry_req[4] = running && halt_req;
    assign entry_req[5] = running && group_halt_req;

    halt_cause_arb #(.N_SRC(N_SRC)) u_arb (
        .req   (entry_req),
        .valid (arb_valid),
        .cause (arb_cause)
    );

    halt_csr_file #(.XLEN(XLEN), .HAS_STOPTIME(HAS_STOPTIME)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wdata     (csr_wdata),
        .cap_en    (arb_valid),
        .cap_cause (arb_cause),
        .cap_priv  (cur_priv),
        .fld       (fld),
        .img       (img)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT: state_d = reset_halt_req ? ST_HALT : ST_RUN;
            ST_RUN,
            ST_STEP: if (arb_valid) state_d = ST_HALT;
            ST_HALT: if (resume_req) state_d = fld.single_step ? ST_STEP : ST_RUN;
            default: state_d = ST_BOOT;
        endcase
    end

    // outputs
    always_comb begin
        debug_mode   = (state_q == ST_HALT);
        irq_mask     = (state_q == ST_STEP) && !fld.step_irq_en;
        count_freeze = fld.freeze_cnt && ((state_q == ST_HALT) || brk_go);
        time_freeze  = fld.freeze_tmr && (state_q == ST_HALT);
        bkpt_exc     = running && ebreak_ret && !brk_en;
        entry_cause  = fld.why;
        resume_priv  = fld.ret_priv;
        csr_rdata    = (addr_hit && state_q == ST_HALT) ? img : '0;
    end

endmodule

// File: rtl/halt_ctrl_chk.sv
module halt_ctrl_chk
    import halt_ctrl_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input hc_state_t  state_q,
    input hc_fields_t fld,
    input logic       instr_ret,
    input logic       resume_req,
    input logic       debug_mode,
    input logic [2:0] entry_cause,
    input logic [1:0] resume_priv,
    input logic       irq_mask,
    input logic       count_freeze,
    input logic       time_freeze,
    input logic       bkpt_exc
);

    p_cause_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        debug_mode |-> entry_cause != 3'd0);

    p_step_reentry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && instr_ret) |=> debug_mode);

    p_resume_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (debug_mode && resume_req) |=> !debug_mode);

    p_count_frz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (debug_mode && fld.freeze_cnt) |-> count_freeze);

    p_time_frz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !debug_mode |-> !time_freeze);

    p_bkpt_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_exc |-> (!debug_mode && !count_freeze));

    p_prv_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resume_priv != PRIV_RSVD);

    p_no_write_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !debug_mode |=> (debug_mode || $stable(fld)));

    p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !debug_mode);

endmodule

bind hart_halt_ctrl halt_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_q      (state_q),
    .fld          (fld),
    .instr_ret    (instr_ret),
    .resume_req   (resume_req),
    .debug_mode   (debug_mode),
    .entry_cause  (entry_cause),
    .resume_priv  (resume_priv),
    .irq_mask     (irq_mask),
    .count_freeze (count_freeze),
    .time_freeze  (time_freeze),
    .bkpt_exc     (bkpt_exc)
);

// File: tb/hart_halt_ctrl_test.sv
`timescale 1ns/1ps
module hart_halt_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = '0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [1:0]  cur_priv = 2'd3;
    logic        ebreak_ret = 0, trig_hit = 0, halt_req = 0, reset_halt_req = 0;
    logic        group_halt_req = 0, resume_req = 0, instr_ret = 0;

    logic [31:0] csr_rdata, rdata0;
    logic        debug_mode, irq_mask, count_freeze, time_freeze, bkpt_exc;
    logic [2:0]  entry_cause;
    logic [1:0]  resume_priv;
    logic        dbg0, irq0, cf0, tf0, bk0;
    logic [2:0]  cause0;
    logic [1:0]  prv0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    hart_halt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .cur_priv(cur_priv),
        .ebreak_ret(ebreak_ret), .trig_hit(trig_hit), .halt_req(halt_req),
        .reset_halt_req(reset_halt_req), .group_halt_req(group_halt_req),
        .resume_req(resume_req), .instr_ret(instr_ret), .debug_mode(debug_mode),
        .entry_cause(entry_cause), .resume_priv(resume_priv), .irq_mask(irq_mask),
        .count_freeze(count_freeze), .time_freeze(time_freeze), .bkpt_exc(bkpt_exc)
    );

    hart_halt_ctrl #(.HAS_STOPTIME(1'b0)) uut_nt (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .csr_rdata(rdata0), .cur_priv(cur_priv),
        .ebreak_ret(ebreak_ret), .trig_hit(trig_hit), .halt_req(halt_req),
        .reset_halt_req(reset_halt_req), .group_halt_req(group_halt_req),
        .resume_req(resume_req), .instr_ret(instr_ret), .debug_mode(dbg0),
        .entry_cause(cause0), .resume_priv(prv0), .irq_mask(irq0),
        .count_freeze(cf0), .time_freeze(tf0), .bkpt_exc(bk0)
    );

    // reference model: 0 boot, 1 run, 2 halted, 3 stepping
    int         m_state;
    logic       m_em, m_es, m_eu, m_sie, m_sc, m_st, m_step;
    logic [2:0] m_cause;
    logic [1:0] m_prv;

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_image();
        return {4'd4, 12'd0, m_em, 1'b0, m_es, m_eu, m_sie, m_sc, m_st,
                m_cause, 3'd0, m_step, m_prv};
    endfunction

    function automatic logic exp_brk_en();
        case (cur_priv)
            2'd3:    return m_em;
            2'd1:    return m_es;
            2'd0:    return m_eu;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check_all();
        logic        run_m, halt_m;
        logic [31:0] erd;
        run_m  = (m_state == 1) || (m_state == 3);
        halt_m = (m_state == 2);
        erd    = (halt_m && csr_addr == 12'h7B0) ? exp_image() : 32'd0;
        chk(debug_mode == halt_m, "R5", "debug_mode", 32'(debug_mode), 32'(halt_m));
        chk(entry_cause == m_cause, "R6", "entry_cause", 32'(entry_cause), 32'(m_cause));
        chk(resume_priv == m_prv, "R11", "resume_priv", 32'(resume_priv), 32'(m_prv));
        chk(irq_mask == (m_state == 3 && !m_sie), "R8", "irq_mask", 32'(irq_mask),
            32'(m_state == 3 && !m_sie));
        chk(count_freeze == (m_sc && (halt_m || (run_m && ebreak_ret && exp_brk_en()))),
            "R9", "count_freeze", 32'(count_freeze),
            32'(m_sc && (halt_m || (run_m && ebreak_ret && exp_brk_en()))));
        chk(time_freeze == (m_st && halt_m), "R10", "time_freeze", 32'(time_freeze),
            32'(m_st && halt_m));
        chk(bkpt_exc == (run_m && ebreak_ret && !exp_brk_en()), "R4", "bkpt_exc",
            32'(bkpt_exc), 32'(run_m && ebreak_ret && !exp_brk_en()));
        chk(csr_rdata == erd, halt_m ? "R3" : "R2", "csr_rdata", csr_rdata, erd);
        chk(tf0 == 1'b0, "R10", "time_freeze hardwired", 32'(tf0), 32'd0);
        chk(rdata0 == (erd & ~32'h200), "R10", "rdata without stoptime", rdata0,
            erd & ~32'h200);
    endtask

    task automatic model_edge();
        logic [2:0] c;
        logic       old_step;
        if (m_state == 0) begin
            if (reset_halt_req) begin
                m_state = 2; m_cause = 3'd5; m_prv = cur_priv;
            end else m_state = 1;
        end else if (m_state == 1 || m_state == 3) begin
            if (trig_hit)                            c = 3'd2;
            else if (ebreak_ret && exp_brk_en())     c = 3'd1;
            else if (m_state == 3 && instr_ret)      c = 3'd4;
            else if (halt_req)                       c = 3'd3;
            else if (group_halt_req)                 c = 3'd6;
            else                                     c = 3'd0;
            if (c != 3'd0) begin
                m_state = 2; m_cause = c; m_prv = cur_priv;
            end
        end else begin
            old_step = m_step;
            if (csr_we && csr_addr == 12'h7B0) begin
                m_em = csr_wdata[15]; m_es = csr_wdata[13]; m_eu = csr_wdata[12];
                m_sie = csr_wdata[11]; m_sc = csr_wdata[10]; m_st = csr_wdata[9];
                m_step = csr_wdata[2];
                if (csr_wdata[1:0] != 2'd2) m_prv = csr_wdata[1:0];
            end
            if (resume_req) m_state = old_step ? 3 : 1;
        end
    endtask

    task automatic tick();
        #1;
        check_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        csr_we = 0; ebreak_ret = 0; trig_hit = 0; halt_req = 0;
        group_halt_req = 0; resume_req = 0; instr_ret = 0;
        csr_addr = 12'h7B0;
    endtask

    task automatic do_reset(input logic rh);
        idle();
        reset_halt_req = rh;
        rst_n = 0;
        repeat (3) @(posedge clk);
        {m_em, m_es, m_eu, m_sie, m_sc, m_st, m_step} = '0;
        m_cause = '0; m_prv = '0; m_state = 0;
        @(negedge clk);
        rst_n = 1;
        tick();
        reset_halt_req = 0;
    endtask

    task automatic wr(input logic [31:0] d);
        idle(); csr_we = 1; csr_wdata = d; tick(); idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);

        // R1: reset-halt held through reset
        cur_priv = 2'd1;
        do_reset(1'b1);
        chk(debug_mode == 1'b1, "R1", "reset halt entry", 32'(debug_mode), 32'd1);
        chk(entry_cause == 3'd5, "R1", "reset halt cause", 32'(entry_cause), 32'd5);

        // R1: plain reset
        cur_priv = 2'd3;
        do_reset(1'b0);
        chk(debug_mode == 1'b0, "R1", "running after reset", 32'(debug_mode), 32'd0);
        chk(entry_cause == 3'd0 && resume_priv == 2'd0, "R1", "fields cleared",
            32'({entry_cause, resume_priv}), 32'd0);
        reset_halt_req = 1; tick(); reset_halt_req = 0; tick();
        chk(debug_mode == 1'b0, "R1", "late reset halt ignored", 32'(debug_mode), 32'd0);

        // R2: write while running ignored
        csr_we = 1; csr_wdata = 32'hFFFF_FFFF; tick(); idle();
        halt_req = 1; tick(); idle(); tick();
        chk(csr_rdata == 32'h4000_00C3, "R2", "write while running ignored",
            csr_rdata, 32'h4000_00C3);
        csr_addr = 12'h7B1; #1;
        chk(csr_rdata == 32'd0, "R2", "other address reads 0", csr_rdata, 32'd0);
        idle();

        // R3/R11: full write, reserved privilege ignored
        wr(32'hFFFF_FFFE); tick();
        chk(csr_rdata == 32'h4000_BEC7, "R3", "image after all-ones write",
            csr_rdata, 32'h4000_BEC7);
        chk(resume_priv == 2'd3, "R11", "reserved priv ignored", 32'(resume_priv), 32'd3);

        // R7/R8/R12: single step, interrupts masked
        wr(32'h0000_0404);
        resume_req = 1; tick(); idle();
        chk(debug_mode == 1'b0, "R12", "resume leaves debug", 32'(debug_mode), 32'd0);
        chk(irq_mask == 1'b1, "R8", "irq masked in step", 32'(irq_mask), 32'd1);
        tick(); tick();
        chk(debug_mode == 1'b0, "R7", "no reentry without retire", 32'(debug_mode), 32'd0);
        cur_priv = 2'd0; instr_ret = 1; tick(); idle();
        chk(debug_mode == 1'b1 && entry_cause == 3'd4, "R7", "step reentry",
            32'({debug_mode, entry_cause}), 32'h0C);
        chk(resume_priv == 2'd0, "R11", "priv captured on entry", 32'(resume_priv), 32'd0);

        // R6/R9: priority and freeze on ebreak
        wr(32'h0000_B403);
        resume_req = 1; tick(); idle();
        cur_priv = 2'd3; trig_hit = 1; ebreak_ret = 1; halt_req = 1; tick(); idle();
        chk(entry_cause == 3'd2, "R6", "trigger beats ebreak", 32'(entry_cause), 32'd2);
        resume_req = 1; tick(); idle();
        ebreak_ret = 1; halt_req = 1; group_halt_req = 1; #1;
        chk(count_freeze == 1'b1, "R9", "freeze on entering ebreak", 32'(count_freeze), 32'd1);
        tick(); idle();
        chk(entry_cause == 3'd1, "R6", "ebreak beats halt", 32'(entry_cause), 32'd1);
        resume_req = 1; tick(); idle();
        halt_req = 1; group_halt_req = 1; tick(); idle();
        chk(entry_cause == 3'd3, "R6", "halt beats group", 32'(entry_cause), 32'd3);

        // R4: disabled ebreak at each privilege
        for (int p = 0; p < 4; p++) begin
            if (p == 2) continue;
            wr(32'h0000_0003);
            resume_req = 1; tick(); idle();
            cur_priv = 2'(p); ebreak_ret = 1; #1;
            chk(bkpt_exc == 1'b1, "R4", "disabled ebreak to exception", 32'(bkpt_exc), 32'd1);
            tick(); idle();
            chk(debug_mode == 1'b0, "R4", "disabled ebreak no entry", 32'(debug_mode), 32'd0);
            halt_req = 1; tick(); idle();
        end

        // random phase
        for (int n = 0; n < 4000; n++) begin
            idle();
            cur_priv       = ($urandom_range(0, 2) == 0) ? 2'd0 :
                             (($urandom_range(0, 1) == 0) ? 2'd1 : 2'd3);
            ebreak_ret     = ($urandom_range(0, 7) == 0);
            trig_hit       = ($urandom_range(0, 15) == 0);
            halt_req       = ($urandom_range(0, 9) == 0);
            group_halt_req = ($urandom_range(0, 15) == 0);
            reset_halt_req = ($urandom_range(0, 7) == 0);
            resume_req     = ($urandom_range(0, 3) == 0);
            instr_ret      = ($urandom_range(0, 1) == 0);
            csr_we         = ($urandom_range(0, 2) == 0);
            csr_addr       = ($urandom_range(0, 3) == 0) ? 12'($urandom) : 12'h7B0;
            csr_wdata      = $urandom;
            tick();
        end
        idle(); reset_halt_req = 0;
        tick();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule